// File: doc/BRIEF.md
# Tristate PWM Gate-Drive Sequencer

This block turns a single PWM command into two gate enables, one for the high-side switch and one for the low-side switch of a synchronous buck stage. Comparators upstream sort the analog PWM level into three classes: high, low and mid-level. The sequencer then produces a break-before-make pattern. It drops the conducting gate first. It turns on the opposite gate only when that gate's feedback reports it has fallen below threshold, and only after a minimum dead time. If the feedback never reports, a timeout lets the sequence continue.

A mid-level PWM input is treated as a phase-shutdown request only after it has lasted for a hold-off window. Until then, the last valid high or low level keeps driving the gates. A low-side diode-emulation option cuts the low side when the inductor current reaches zero, for light-load operation. The disable input and the supply-good input override everything else and clamp both gates low in the same cycle.

Top module: `gd_ctrl`

## Requirements
- R1: While rst_ni is low, and on the first cycle after its release, both gate outputs are 0.
- R2: When pwm_lvl_i is 2'b01 (high), ls_gate_o goes low on the next clock edge. hs_gate_o rises only after the block has spent at least MIN_DEAD_CYC cycles with both gates off and ls_fb_low_i is 1. With the feedback already present, hs_gate_o is 1 exactly MIN_DEAD_CYC+1 edges after the command.
- R3: When pwm_lvl_i is 2'b00 (low), the same rule applies with the roles swapped. hs_gate_o drops first, and ls_gate_o waits on hs_fb_low_i and on the minimum dead time.
- R4: If the feedback of the gate being turned off stays 0, the other gate is enabled anyway after FB_TIMEOUT_CYC cycles with both gates off.
- R5: pwm_lvl_i of 2'b10 or 2'b11 is mid-level. Once HOLDOFF_CYC consecutive mid-level samples have been taken, both gates are off. After HOLDOFF_CYC-1 such samples, the previous drive is still in place.
- R6: Any high or low sample inside the mid-level window restarts the hold-off count.
- R7: While dis_ni is 0, both gate outputs are 0 in the same cycle, whatever the other inputs are.
- R8: While uv_ok_i is 0, both gate outputs are 0 in the same cycle, and they stay 0 until the supply is good again.
- R9: After disable or undervoltage is released, a mid-level input enables neither gate. The sequence starts only on a high or low level.
- R10: With de_sel_ni at 0, an on low-side gate is switched off on the edge that samples zc_i at 1. It stays off, even if zc_i returns to 0, until the next high level.
- R11: With de_sel_ni at 1, zc_i has no effect and the low side follows a low PWM level.
- R12: hs_gate_o and ls_gate_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_lvl_i | input | 2 | Classified PWM: 00 low, 01 high, 1x mid-level |
| dis_ni | input | 1 | Disable, active low; a floating pin reads as 0 |
| de_sel_ni | input | 1 | Diode-emulation select, active low |
| uv_ok_i | input | 1 | Supply above the lockout threshold |
| zc_i | input | 1 | Inductor current at or below zero |
| hs_fb_low_i | input | 1 | High-side gate is below its turn-on threshold |
| ls_fb_low_i | input | 1 | Low-side gate is below its turn-on threshold |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |

## Verification
The bench counts edges to pin down the exact cycle when each gate turns on after a level change. A sequencer that skipped the dead time, or that ignored the opposite gate's feedback, would turn a gate on early. The bench runs the mid-level window one sample short of expiry and again after an interruption. A design with an off-by-one counter or a missing restart would shut the phase too early or too late. Diode-emulation cutoff is checked with zc_i released again, to catch a low side that switches back on before the next high level. A restart after disable is checked with a mid-level input, to catch a block that leaves shutdown from the mid-level state.

// File: rtl/gd_pkg.sv
package gd_pkg;
  localparam logic [1:0] PWM_LO = 2'b00;
  localparam logic [1:0] PWM_HI = 2'b01;

  typedef enum logic [1:0] {CMD_OFF, CMD_HI, CMD_LO} cmd_e;

  typedef enum logic [2:0] {
    ST_OFF, ST_WAIT_HS, ST_HS_ON, ST_WAIT_LS, ST_LS_ON, ST_LS_CUT
  } seq_st_e;
endpackage

// File: rtl/gd_holdoff.sv
module gd_holdoff
  import gd_pkg::*;
#(
  parameter int HOLDOFF_CYC = 30
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [1:0] pwm_lvl_i,
  output cmd_e       cmd_o
);
  localparam int CW = $clog2(HOLDOFF_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(HOLDOFF_CYC);
  localparam logic [CW-1:0] CEXP = CW'(HOLDOFF_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_hi_q, valid_q;
  logic          is_hi, is_lo, is_mid, tri_off;

  assign is_hi   = (pwm_lvl_i == PWM_HI);
  assign is_lo   = (pwm_lvl_i == PWM_LO);
  assign is_mid  = !is_hi && !is_lo;
  assign tri_off = is_mid && (cnt_q >= CEXP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      lvl_hi_q <= 1'b0;
      valid_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q    <= '0;
      valid_q  <= 1'b0;
    end else begin
      if (!is_mid) begin
        cnt_q    <= '0;
        lvl_hi_q <= is_hi;
        valid_q  <= 1'b1;
      end else if (cnt_q < CMAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (is_hi)                     cmd_o = CMD_HI;
    else if (is_lo)                cmd_o = CMD_LO;
    else if (tri_off || !valid_q)  cmd_o = CMD_OFF;
    else                           cmd_o = lvl_hi_q ? CMD_HI : CMD_LO;
  end

  p_cnt_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_mid |=> (cnt_q == '0));
endmodule

// File: rtl/gd_seq.sv
module gd_seq
  import gd_pkg::*;
#(
  parameter int MIN_DEAD_CYC   = 2,
  parameter int FB_TIMEOUT_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kill_i,
  input  cmd_e cmd_i,
  input  logic de_mode_i,
  input  logic zc_i,
  input  logic hs_fb_low_i,
  input  logic ls_fb_low_i,
  output logic hs_on_o,
  output logic ls_on_o
);
  localparam int DW = $clog2(FB_TIMEOUT_CYC + 1);
  localparam logic [DW-1:0] DMIN = DW'(MIN_DEAD_CYC - 1);
  localparam logic [DW-1:0] DTO  = DW'(FB_TIMEOUT_CYC - 1);
  localparam logic [DW-1:0] DMAX = DW'(FB_TIMEOUT_CYC);

  seq_st_e       st_q, st_d;
  logic [DW-1:0] dt_q;
  logic          in_wait, go_hs, go_ls;

  assign in_wait = (st_q == ST_WAIT_HS) || (st_q == ST_WAIT_LS);
  // leave the dead window on confirmed feedback after the minimum, or on timeout
  assign go_hs = (ls_fb_low_i && dt_q >= DMIN) || (dt_q >= DTO);
  assign go_ls = (hs_fb_low_i && dt_q >= DMIN) || (dt_q >= DTO);

  always_comb begin
    st_d = st_q;
    if (kill_i || cmd_i == CMD_OFF) begin
      st_d = ST_OFF;
    end else if (cmd_i == CMD_HI) begin
      case (st_q)
        ST_HS_ON:   st_d = ST_HS_ON;
        ST_WAIT_HS: st_d = go_hs ? ST_HS_ON : ST_WAIT_HS;
        default:    st_d = ST_WAIT_HS;
      endcase
    end else begin
      case (st_q)
        ST_LS_ON:   st_d = (de_mode_i && zc_i) ? ST_LS_CUT : ST_LS_ON;
        ST_LS_CUT:  st_d = ST_LS_CUT;
        ST_WAIT_LS: st_d = go_ls ? ST_LS_ON : ST_WAIT_LS;
        default:    st_d = ST_WAIT_LS;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_OFF;
      dt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q)                 dt_q <= '0;
      else if (in_wait && dt_q < DMAX)  dt_q <= dt_q + 1'b1;
    end
  end

  assign hs_on_o = (st_q == ST_HS_ON);
  assign ls_on_o = (st_q == ST_LS_ON);

  p_bbm_hs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_on_o) |-> !$past(ls_on_o));
  p_bbm_ls_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_on_o) |-> !$past(hs_on_o));
endmodule

// File: rtl/gd_ctrl.sv
module gd_ctrl
  import gd_pkg::*;
#(
  parameter int HOLDOFF_CYC    = 30,
  parameter int MIN_DEAD_CYC   = 2,
  parameter int FB_TIMEOUT_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pwm_lvl_i,
  input  logic       dis_ni,
  input  logic       de_sel_ni,
  input  logic       uv_ok_i,
  input  logic       zc_i,
  input  logic       hs_fb_low_i,
  input  logic       ls_fb_low_i,
  output logic       hs_gate_o,
  output logic       ls_gate_o
);
  logic kill, hs_on, ls_on;
  cmd_e cmd;

  assign kill = !dis_ni || !uv_ok_i;

  gd_holdoff #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_holdoff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (kill),
    .pwm_lvl_i (pwm_lvl_i),
    .cmd_o     (cmd)
  );

  gd_seq #(.MIN_DEAD_CYC(MIN_DEAD_CYC), .FB_TIMEOUT_CYC(FB_TIMEOUT_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .kill_i      (kill),
    .cmd_i       (cmd),
    .de_mode_i   (!de_sel_ni),
    .zc_i        (zc_i),
    .hs_fb_low_i (hs_fb_low_i),
    .ls_fb_low_i (ls_fb_low_i),
    .hs_on_o     (hs_on),
    .ls_on_o     (ls_on)
  );

  // immediate clamp, not waiting for the state register
  assign hs_gate_o = hs_on && !kill;
  assign ls_gate_o = ls_on && !kill;

  p_kill_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill |-> (!hs_gate_o && !ls_gate_o));
  p_no_overlap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_gate_o && ls_gate_o));
endmodule

// File: tb/gd_ctrl_tb.sv
`timescale 1ns/1ps
module gd_ctrl_tb_top;
  localparam int HO = 30;
  localparam int MD = 2;
  localparam int TO = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] pwm = 2'b00;
  logic dis_n = 1'b1, de_n = 1'b1, uv_ok = 1'b1, zc = 1'b0;
  logic hs_fb = 1'b1, ls_fb = 1'b1;
  logic hs, ls;
  int n_chk = 0, n_fail = 0, n_overlap = 0;

  always #2.5 clk = ~clk;

  gd_ctrl #(.HOLDOFF_CYC(HO), .MIN_DEAD_CYC(MD), .FB_TIMEOUT_CYC(TO)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_lvl_i(pwm), .dis_ni(dis_n),
    .de_sel_ni(de_n), .uv_ok_i(uv_ok), .zc_i(zc),
    .hs_fb_low_i(hs_fb), .ls_fb_low_i(ls_fb),
    .hs_gate_o(hs), .ls_gate_o(ls));

  always @(negedge clk) if (rst_ni && hs && ls) n_overlap++;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {hs,ls} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    #1 chk("R1", {hs, ls}, 2'b00);
    tick(2); rst_ni = 1'b1;
    tick(1); chk("R1", {hs, ls}, 2'b00);
  endtask

  task automatic t_high_low;
    pwm = 2'b01;
    tick(MD); chk("R2", {hs, ls}, 2'b00);
    tick(1);  chk("R2", {hs, ls}, 2'b10);
    pwm = 2'b00;
    tick(1);  chk("R3", {hs, ls}, 2'b00);
    tick(MD - 1); chk("R3", {hs, ls}, 2'b00);
    tick(1);  chk("R3", {hs, ls}, 2'b01);
  endtask

  task automatic t_timeout;
    ls_fb = 1'b0; pwm = 2'b01;
    tick(MD + 1); chk("R2", {hs, ls}, 2'b00);
    tick(TO - MD - 1); chk("R4", {hs, ls}, 2'b00);
    tick(1); chk("R4", {hs, ls}, 2'b10);
    ls_fb = 1'b1;
  endtask

  task automatic t_holdoff;
    pwm = 2'b10;
    tick(HO - 1); chk("R5", {hs, ls}, 2'b10);
    pwm = 2'b01; tick(1);
    pwm = 2'b11;
    tick(HO - 1); chk("R6", {hs, ls}, 2'b10);
    tick(1); chk("R5", {hs, ls}, 2'b00);
    tick(3); chk("R5", {hs, ls}, 2'b00);
    pwm = 2'b00;
    tick(MD + 1); chk("R3", {hs, ls}, 2'b01);
  endtask

  task automatic t_disable;
    dis_n = 1'b0; #1;
    chk("R7", {hs, ls}, 2'b00);
    pwm = 2'b01; tick(MD + 2); chk("R7", {hs, ls}, 2'b00);
    pwm = 2'b10; dis_n = 1'b1;
    tick(HO + 4); chk("R9", {hs, ls}, 2'b00);
    pwm = 2'b01;
    tick(MD + 1); chk("R9", {hs, ls}, 2'b10);
  endtask

  task automatic t_uvlo;
    uv_ok = 1'b0; #1;
    chk("R8", {hs, ls}, 2'b00);
    tick(4); chk("R8", {hs, ls}, 2'b00);
    uv_ok = 1'b1;
    tick(1); chk("R8", {hs, ls}, 2'b00);
    tick(MD); chk("R8", {hs, ls}, 2'b10);
  endtask

  task automatic t_diode_em;
    de_n = 1'b0; pwm = 2'b00;
    tick(MD + 1); chk("R10", {hs, ls}, 2'b01);
    zc = 1'b1; tick(1); chk("R10", {hs, ls}, 2'b00);
    zc = 1'b0; tick(5); chk("R10", {hs, ls}, 2'b00);
    pwm = 2'b01; tick(MD + 1); chk("R10", {hs, ls}, 2'b10);
    pwm = 2'b00; tick(MD + 1); chk("R10", {hs, ls}, 2'b01);
  endtask

  task automatic t_ccm;
    de_n = 1'b1; zc = 1'b1;
    tick(5); chk("R11", {hs, ls}, 2'b01);
    zc = 1'b0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_high_low();
    t_timeout();
    t_holdoff();
    t_disable();
    t_uvlo();
    t_diode_em();
    t_ccm();
    n_chk++;
    if (n_overlap != 0) begin
      n_fail++;
      $display("FAIL R12: overlap cycles actual %0d expected 0", n_overlap);
    end
    summary();
  end
endmodule